// File: doc/BRIEF.md
# Dual-Output Sawtooth PWM Timer

This block is one PWM timer channel. A 32-bit counter counts up from zero to a programmed period value and then returns to zero, which gives a sawtooth. A prescaler divides the input clock by a power of four, so the counter advances once every 1, 4, 16, 64, 256 or 1024 clocks. Two output pins share the counter, the period and the prescaler. Each pin has its own compare register. A pin is high from the start of a cycle until the counter reaches its compare value, and low for the rest of the cycle.

Software programs the channel through a flat word-addressed register port with a single-cycle write strobe and a combinational read path. To use it, software stops the counter, sets the mode, prescale, period, compares and direction, and clears the counter. It then enables each pin with the sawtooth action code and sets the start bit. Clearing the start bit, or clearing a pin's enable, drives that pin low.

Top module: `pwm_saw_timer`

## Requirements
- R1: After reset every register reads 0 and both pins are low.
- R2: The counter advances only while the start bit (control bit 0) is 1, the mode field (control bits 18:16) is 0 and the direction register bits 1:0 are both 1. Otherwise the counter holds its value.
- R3: With prescale code n in control bits 26:24 (codes above 5 act as 5), the counter advances once every 4^n clocks.
- R4: At an advance where the counter is at or above the period register, the counter becomes 0. At any other advance it goes up by one, so one full cycle lasts (period+1)×4^n clocks.
- R5: A running, enabled pin is high for compare×4^n clocks in each cycle when 0 < compare < period, and its rising edges are (period+1)×4^n clocks apart.
- R6: A compare value of 0 holds the pin constantly low.
- R7: A compare value at or above the period holds the pin constantly high while running.
- R8: The output-control register holds a pin-enable bit for each pin: bit 8 for pin A, bit 24 for pin B. A disabled pin is low, and this does not affect the other pin.
- R9: When the start bit is cleared, both pins are low from the clock after the write onward.
- R10: Writes to the mode and prescale fields are ignored while the stored start bit is 1.
- R11: The output-control register holds a 5-bit action code for each pin: bits 4:0 for pin A, bits 20:16 for pin B. A pin is driven only when its code is 0x1B; any other code keeps it low.
- R12: Software can write the counter register at any time, and the written value reads back.
- R13: Register byte offsets are: control 0x00, direction 0x04, output control 0x08, buffer enable 0x0C (bits 1:0 stored), counter 0x10, compare A 0x14, compare B 0x18, period 0x1C. Each register reads back what was written into its stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| pin_a_o | output | 1 | PWM output A |
| pin_b_o | output | 1 | PWM output B |

## Verification
The main sweep covers prescale codes 0 to 2 and two period values. In each case pin A and pin B get different compare values, taken from zero, one, just below the period, equal to the period and above it. Counting high clocks over a two-cycle window separates a wrong duty from a wrong division. Measuring the spacing of rising edges separates an off-by-one in the wrap from an error in the prescaler. Running the two pins with different compares at the same time shows whether their compare paths are crossed. Separate scenarios stop the counter, disable one pin, use a foreign action code, try a prescale write while running, and set a non-up direction. Each of these would otherwise leave the pin waveform intact.

// File: rtl/pwm_saw_pkg.sv
package pwm_saw_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned MAX_CODE = 5;
  localparam int unsigned NUM_PINS = 2;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_DIR  = 3'd1;
  localparam logic [2:0] OFS_OCTL = 3'd2;
  localparam logic [2:0] OFS_BUF  = 3'd3;
  localparam logic [2:0] OFS_CNT  = 3'd4;
  localparam logic [2:0] OFS_CMPA = 3'd5;
  localparam logic [2:0] OFS_CMPB = 3'd6;
  localparam logic [2:0] OFS_PER  = 3'd7;

  localparam logic [4:0] ACT_SAW  = 5'h1B;
  localparam logic [2:0] MODE_SAW = 3'd0;
  localparam logic [1:0] DIR_UP   = 2'b11;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned MAX_CODE = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [2:0] code_i,
  output logic       tick_o
);
  localparam int unsigned DIV_W = 2 * MAX_CODE;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;
  logic [2:0]       code_eff;

  assign code_eff = (code_i > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code_i;

  always_comb begin
    limit = '0;
    for (int k = 0; k < int'(MAX_CODE); k++)
      if (k < int'(code_eff)) limit[2*k +: 2] = 2'b11;
  end

  assign tick_o = run_i && !clr_i && (div_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || clr_i)   div_q <= '0;
    else if (tick_o)            div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  // R3: a divided tick is never followed by another one in the next clock
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && code_i != 3'd0 && $stable(code_i)) |=> !tick_o);
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (tick_i)   cnt_q <= (cnt_q >= period_i) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R4: an advance at or past the period wraps to zero
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q >= period_i) |=> (cnt_o == '0));
  // R4: an advance below the period steps by one
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q < period_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pwm_pin.sv
module pwm_pin #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         en_i,
  input  logic [4:0]   act_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] period_i,
  output logic         pin_o
);
  import pwm_saw_pkg::*;

  logic level;
  logic pin_q;

  // set at cycle start, cleared at compare match; a match at or past the
  // period coincides with the cycle-end set, so the pin stays high
  assign level = (cmp_i >= period_i) || (cnt_i < cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= run_i && en_i && (act_i == ACT_SAW) && level;
  end

  assign pin_o = pin_q;

  a_r9_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pin_o);
  a_r8_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pin_o);
  a_r6_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == '0) |=> !pin_o);
  a_r11_code_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i != ACT_SAW) |=> !pin_o);
  a_r7_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_i && act_i == ACT_SAW && cmp_i != '0 && cmp_i >= period_i) |=> pin_o);
endmodule

// File: rtl/pwm_saw_timer.sv
module pwm_saw_timer
  import pwm_saw_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned NCODE  = MAX_CODE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic          pin_a_o,
  output logic          pin_b_o
);
  localparam int unsigned NP = NUM_PINS;

  logic [2:0]   sel;
  logic         start_q;
  logic [2:0]   mode_q;
  logic [2:0]   presc_q;
  logic [1:0]   dir_q;
  logic [1:0]   buf_q;
  logic [4:0]   act_q [NP];
  logic         en_q  [NP];
  logic [W-1:0] cmp_q [NP];
  logic [W-1:0] period_q;
  logic [W-1:0] cnt;
  logic         run;
  logic         tick;
  logic         cnt_load;
  logic [NP-1:0] pins;

  assign sel      = reg_addr_i[4:2];
  assign cnt_load = reg_we_i && (sel == OFS_CNT);
  assign run      = start_q && (mode_q == MODE_SAW) && (dir_q == DIR_UP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      mode_q   <= '0;
      presc_q  <= '0;
      dir_q    <= '0;
      buf_q    <= '0;
      period_q <= '0;
      for (int i = 0; i < int'(NP); i++) begin
        act_q[i] <= '0;
        en_q[i]  <= 1'b0;
        cmp_q[i] <= '0;
      end
    end else if (reg_we_i) begin
      unique case (sel)
        OFS_CTRL: begin
          start_q <= reg_wdata_i[0];
          if (!start_q) begin
            mode_q  <= reg_wdata_i[18:16];
            presc_q <= reg_wdata_i[26:24];
          end
        end
        OFS_DIR:  dir_q <= reg_wdata_i[1:0];
        OFS_OCTL: begin
          act_q[0] <= reg_wdata_i[4:0];
          en_q[0]  <= reg_wdata_i[8];
          act_q[1] <= reg_wdata_i[20:16];
          en_q[1]  <= reg_wdata_i[24];
        end
        OFS_BUF:  buf_q    <= reg_wdata_i[1:0];
        OFS_CMPA: cmp_q[0] <= reg_wdata_i;
        OFS_CMPB: cmp_q[1] <= reg_wdata_i;
        OFS_PER:  period_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      OFS_CTRL: begin
        reg_rdata_o[0]     = start_q;
        reg_rdata_o[18:16] = mode_q;
        reg_rdata_o[26:24] = presc_q;
      end
      OFS_DIR:  reg_rdata_o[1:0] = dir_q;
      OFS_OCTL: begin
        reg_rdata_o[4:0]   = act_q[0];
        reg_rdata_o[8]     = en_q[0];
        reg_rdata_o[20:16] = act_q[1];
        reg_rdata_o[24]    = en_q[1];
      end
      OFS_BUF:  reg_rdata_o[1:0] = buf_q;
      OFS_CNT:  reg_rdata_o = cnt;
      OFS_CMPA: reg_rdata_o = cmp_q[0];
      OFS_CMPB: reg_rdata_o = cmp_q[1];
      OFS_PER:  reg_rdata_o = period_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  pwm_prescale #(.MAX_CODE(NCODE)) i_prescale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (cnt_load),
    .code_i(presc_q),
    .tick_o(tick)
  );

  pwm_count #(.W(W)) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .load_i    (cnt_load),
    .load_val_i(reg_wdata_i),
    .period_i  (period_q),
    .cnt_o     (cnt)
  );

  for (genvar g = 0; g < int'(NP); g++) begin : g_pin
    pwm_pin #(.W(W)) i_pin (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run),
      .en_i    (en_q[g]),
      .act_i   (act_q[g]),
      .cnt_i   (cnt),
      .cmp_i   (cmp_q[g]),
      .period_i(period_q),
      .pin_o   (pins[g])
    );
  end

  assign pin_a_o = pins[0];
  assign pin_b_o = pins[1];

  // R2: counter frozen when not running and not written
  a_r2_frozen_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_load) |=> $stable(cnt));
  // R10: mode and prescale locked while started
  a_r10_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> ($stable(presc_q) && $stable(mode_q)));
  // R9: a stop write clears both pins one clock later
  a_r9_stop_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && sel == OFS_CTRL && !reg_wdata_i[0]) |=> ##1 (!pin_a_o && !pin_b_o));
endmodule

// File: tb/test_pwm_saw_timer.sv
module test_pwm_saw_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pa, pb;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  localparam logic [31:0] OCTL_BOTH = 32'h011B_011B;

  pwm_saw_timer i_pwm_saw_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_a_o(pa), .pin_b_o(pb)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog: act=%0d exp<150000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic setup(input int n, input int per, input int ca, input int cb, input logic [31:0] octl);
    wr(5'h00, 32'h0);
    wr(5'h00, 32'(n) << 24);
    wr(5'h1C, 32'(per));
    wr(5'h14, 32'(ca));
    wr(5'h18, 32'(cb));
    wr(5'h10, 32'h0);
    wr(5'h08, octl);
    wr(5'h04, 32'h3);
    wr(5'h00, (32'(n) << 24) | 32'h1);
  endtask

  task automatic count_high(input int w, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      ha += int'(pa); hb += int'(pb);
    end
  endtask

  task automatic rise_gap(input int lim, output int gap, output int hi);
    logic prev;
    int k;
    gap = -1; hi = 0;
    @(negedge clk); prev = pa;
    k = 0;
    while (!(pa && !prev) && k < lim) begin prev = pa; @(negedge clk); k++; end
    k = 0;
    prev = pa;
    do begin
      hi += int'(pa);
      prev = pa; @(negedge clk); k++;
    end while (!(pa && !prev) && k < lim);
    gap = k;
  endtask

  function automatic int eff(input int c, input int per);
    if (c == 0) return 0;
    if (c >= per) return per + 1;
    return c;
  endfunction

  initial begin
    logic [31:0] d;
    int ha, hb, gap, hi, m, cl, w;
    int cvals[5];

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pa == 1'b0 && pb == 1'b0, "R1 pins", {pa, pb}, 0);
    for (int r = 0; r < 8; r++) begin
      rd(5'(r * 4), d);
      chk(d == 0, "R1 reg", d, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R13 register map
    wr(5'h04, 32'h3);       rd(5'h04, d); chk(d == 32'h3, "R13 dir", d, 3);
    wr(5'h0C, 32'hFFFF);    rd(5'h0C, d); chk(d == 32'h3, "R13 buf", d, 3);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); chk(d == 32'h011F_011F, "R13 octl", d, 32'h011F_011F);
    wr(5'h14, 32'hA5A5_0001); rd(5'h14, d); chk(d == 32'hA5A5_0001, "R13 cmpa", d, 32'hA5A5_0001);
    wr(5'h18, 32'h0F0F_0002); rd(5'h18, d); chk(d == 32'h0F0F_0002, "R13 cmpb", d, 32'h0F0F_0002);
    wr(5'h1C, 32'h1234_5678); rd(5'h1C, d); chk(d == 32'h1234_5678, "R13 per", d, 32'h1234_5678);
    wr(5'h00, 32'h0203_0000); rd(5'h00, d); chk(d == 32'h0203_0000, "R13 ctrl", d, 32'h0203_0000);

    // R12 counter write, R2 held while stopped
    wr(5'h10, 32'h1234); rd(5'h10, d); chk(d == 32'h1234, "R12 cnt wr", d, 32'h1234);
    repeat (10) @(negedge clk);
    rd(5'h10, d); chk(d == 32'h1234, "R2 stopped hold", d, 32'h1234);

    // R3 R4 R5 R6 R7 sweep
    for (int n = 0; n < 3; n++) begin
      m = 1 << (2 * n);
      for (int pi = 0; pi < 2; pi++) begin
        int per;
        per = (pi == 0) ? 2 : 5;
        cvals = '{0, 1, per - 1, per, per + 3};
        for (int ci = 0; ci < 5; ci++) begin
          int ca, cb;
          ca = cvals[ci];
          cb = cvals[(ci + 2) % 5];
          cl = (per + 1) * m;
          setup(n, per, ca, cb, OCTL_BOTH);
          repeat (cl + 4) @(negedge clk);
          w = 2 * cl;
          count_high(w, ha, hb);
          if (ca == 0)        chk(ha == 0, "R6 A zero", ha, 0);
          else if (ca >= per) chk(ha == w, "R7 A full", ha, w);
          else                chk(ha == 2 * ca * m, "R5 A high", ha, 2 * ca * m);
          if (cb == 0)        chk(hb == 0, "R6 B zero", hb, 0);
          else if (cb >= per) chk(hb == w, "R7 B full", hb, w);
          else                chk(hb == 2 * eff(cb, per) * m, "R5 B high", hb, 2 * cb * m);
          if (ca > 0 && ca < per) begin
            rise_gap(4 * cl, gap, hi);
            chk(gap == cl, "R3 R4 period", gap, cl);
            chk(hi == ca * m, "R5 A run", hi, ca * m);
          end
        end
        rd(5'h10, d); chk(d <= 32'(per), "R4 cnt bound", d, per);
      end
    end

    // R9 stop forces both pins low within one clock
    setup(1, 3, 10, 10, OCTL_BOTH);
    repeat (8) @(negedge clk);
    chk(pa && pb, "R9 pre high", {pa, pb}, 3);
    wr(5'h00, 32'h0100_0000);
    @(negedge clk);
    chk(!pa && !pb, "R9 stop low", {pa, pb}, 0);

    // R10 prescale and mode writes ignored while running
    setup(1, 3, 2, 2, OCTL_BOTH);
    wr(5'h00, 32'h0207_0001);
    rd(5'h00, d); chk(d == 32'h0100_0001, "R10 locked", d, 32'h0100_0001);
    rise_gap(200, gap, hi);
    chk(gap == 16, "R10 period kept", gap, 16);

    // R8 pin A disabled, pin B unaffected
    setup(0, 3, 10, 10, 32'h011B_001B);
    repeat (4) @(negedge clk);
    count_high(8, ha, hb);
    chk(ha == 0, "R8 A off", ha, 0);
    chk(hb == 8, "R8 B on", hb, 8);

    // R11 foreign action code keeps pin low
    setup(0, 3, 10, 10, 32'h011B_010A);
    repeat (4) @(negedge clk);
    count_high(8, ha, hb);
    chk(ha == 0, "R11 A code", ha, 0);
    chk(hb == 8, "R11 B code", hb, 8);

    // R2 non-up direction holds the counter and pins
    setup(0, 9, 10, 10, OCTL_BOTH);
    wr(5'h04, 32'h1);
    rd(5'h10, d);
    begin
      logic [31:0] d2;
      repeat (6) @(negedge clk);
      rd(5'h10, d2);
      chk(d2 == d, "R2 dir hold", d2, d);
    end
    chk(!pa, "R2 dir pin low", pa, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule